// File: doc/BRIEF.md
# Framed Three-Wire Programming Receiver

This block takes a serial programming stream made of a bus clock, a data line and an active-low enable, and turns it into two parallel ratio words. While enable is low, every rising edge of the bus clock shifts one data bit into a 15-bit register, most significant bit first. Older bits fall off the top, and the number of bits in a burst is never checked. When enable returns high, the register contents are copied into one of two latches, a transmit latch or a receive latch. The bit that was shifted in last picks the latch.

All logic runs on a fast system clock. The three bus lines pass through two-flop synchronizers, and the bus edges are found by comparing each line with its previous value. If enable rises while the bus clock is low, that rise is treated as one more shift edge. The extra shift happens before the transfer. An active-low power-down input clears the shift register and both latches. Each latch has an update strobe that is high for one system clock when that latch is written.

Top module: `serprog_rx`

## Requirements
- R1: While enable is low, each rising bus-clock edge shifts the data line into the register at bit 0, most significant bit first. After a transfer, the ratio output holds register bits 14 down to 2.
- R2: Bus-clock edges and data are ignored while enable is high. Such edges do not change the register contents seen by the next burst.
- R3: A latch changes only when enable rises. During a burst, both ratio outputs keep their old values.
- R4: Register bit 0 selects the destination latch: 1 selects the transmit latch, 0 selects the receive latch. The latch that is not selected keeps its value.
- R5: Only the 15 most recent bits are kept. A burst longer than 15 bits leaves exactly its last 15 bits in the register.
- R6: If enable rises while the bus clock is low, the data line is shifted in once more before the transfer. If enable and the bus clock rise in the same system cycle, exactly one shift takes place.
- R7: Each transfer raises the strobe of the written latch (tx_upd or rx_upd) for exactly one system clock. The two strobes are never high together.
- R8: While pd_n is low, the register and both latches are cleared to zero and both strobes stay low.
- R9: After a synchronous reset, both ratio outputs are zero and both strobes are low.
- R10: Register bit 1 is reserved. Its value does not affect either ratio output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pd_n | input | 1 | Active-low power-down; clears the register and both latches |
| bus_clk | input | 1 | Serial bus clock; the rising edge is active |
| bus_dat | input | 1 | Serial bus data, most significant bit first |
| bus_en_n | input | 1 | Active-low burst enable; its rising edge triggers the transfer |
| tx_ratio | output | 13 | Transmit latch ratio word |
| rx_ratio | output | 13 | Receive latch ratio word |
| tx_upd | output | 1 | One-cycle strobe when the transmit latch is written |
| rx_upd | output | 1 | One-cycle strobe when the receive latch is written |

## Verification
A shift and a latch transfer can happen in the same system cycle. This occurs when enable rises while the bus clock is low, which forces the extra shift. It also occurs when the bus clock and enable rise in the same system cycle. The bench creates both cases in directed tests and in randomly chosen burst endings. It checks the result against a model that always applies the shift before it copies the word. So any design that transfers the stale word or loses the shift ends up with the wrong ratio or the wrong destination latch.

// File: rtl/serprog_pkg.sv
`timescale 1ns/1ps
package serprog_pkg;
  localparam int SP_WORD_W  = 15;
  localparam int SP_RATIO_W = 13;
  localparam int SP_SYNC_N  = 2;

  typedef enum logic {
    DEST_RX = 1'b0,
    DEST_TX = 1'b1
  } dest_e;
endpackage

// File: rtl/serprog_sync.sv
`timescale 1ns/1ps
// Multi-stage synchronizer, one chain per input bit.
module serprog_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= {STAGES{RST_VAL[b]}};
      else     chain <= {chain[STAGES-2:0], din[b]};
    end
    assign dout[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serprog_edge.sv
`timescale 1ns/1ps
// Turns synchronized bus clock and enable into shift and transfer events.
module serprog_edge (
  input  logic clk,
  input  logic rst,
  input  logic s_clk,
  input  logic s_en,
  output logic shift_ev,
  output logic xfer_ev,
  output logic en_idle
);
  logic s_clk_d, s_en_d;
  logic clk_rise, en_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      s_clk_d <= 1'b0;
      s_en_d  <= 1'b1;
    end else begin
      s_clk_d <= s_clk;
      s_en_d  <= s_en;
    end
  end

  assign clk_rise = s_clk & ~s_clk_d;
  assign en_rise  = s_en & ~s_en_d;
  // a clock rise counts only while the burst is open; an enable rise with
  // the bus clock low counts as one extra shift edge
  assign shift_ev = (clk_rise & ~s_en_d) | (en_rise & ~s_clk);
  assign xfer_ev  = en_rise;
  assign en_idle  = s_en & s_en_d;

  AST_XFER_SPACED: assert property (@(posedge clk) disable iff (rst)
    xfer_ev |=> !xfer_ev); // R7
endmodule

// File: rtl/serprog_shreg.sv
`timescale 1ns/1ps
// Serial-in register keeping the newest WORD_W bits.
module serprog_shreg #(
  parameter int WORD_W = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              shift_en,
  input  logic              din,
  output logic [WORD_W-1:0] word,
  output logic [WORD_W-1:0] next_word
);
  assign next_word = shift_en ? {word[WORD_W-2:0], din} : word;

  always_ff @(posedge clk) begin
    if (rst || clr) word <= '0;
    else            word <= next_word;
  end

  AST_CLR_WORD: assert property (@(posedge clk) disable iff (rst)
    clr |=> (word == '0)); // R8
endmodule

// File: rtl/serprog_latch.sv
`timescale 1ns/1ps
// Transmit and receive latches with steering by the select bit.
module serprog_latch
  import serprog_pkg::*;
#(
  parameter int WORD_W  = 15,
  parameter int RATIO_W = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic               load,
  input  logic [WORD_W-1:0]  word,
  output logic [RATIO_W-1:0] tx_ratio,
  output logic [RATIO_W-1:0] rx_ratio,
  output logic               tx_upd,
  output logic               rx_upd
);
  localparam int RSV_W = WORD_W - RATIO_W - 1;

  dest_e             dest;
  logic [RATIO_W-1:0] ratio_fld;
  logic [RSV_W-1:0]   unused_rsv_bits;

  assign dest            = dest_e'(word[0]);
  assign ratio_fld       = word[WORD_W-1 -: RATIO_W];
  assign unused_rsv_bits = word[RSV_W:1];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      tx_ratio <= '0;
      rx_ratio <= '0;
      tx_upd   <= 1'b0;
      rx_upd   <= 1'b0;
    end else begin
      tx_upd <= 1'b0;
      rx_upd <= 1'b0;
      if (load) begin
        if (dest == DEST_TX) begin
          tx_ratio <= ratio_fld;
          tx_upd   <= 1'b1;
        end else begin
          rx_ratio <= ratio_fld;
          rx_upd   <= 1'b1;
        end
      end
    end
  end

  AST_UPD_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(tx_upd && rx_upd)); // R7
  AST_TX_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    (tx_ratio != $past(tx_ratio)) |-> (tx_upd || $past(clr))); // R3
  AST_RX_ONLY_ON_UPD: assert property (@(posedge clk) disable iff (rst)
    (rx_ratio != $past(rx_ratio)) |-> (rx_upd || $past(clr))); // R3
  AST_CLR_LATCH: assert property (@(posedge clk) disable iff (rst)
    clr |=> (tx_ratio == '0 && rx_ratio == '0 && !tx_upd && !rx_upd)); // R8
endmodule

// File: rtl/serprog_rx.sv
`timescale 1ns/1ps
module serprog_rx
  import serprog_pkg::*;
#(
  parameter int WORD_W  = SP_WORD_W,
  parameter int RATIO_W = SP_RATIO_W,
  parameter int SYNC_N  = SP_SYNC_N
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pd_n,
  input  logic               bus_clk,
  input  logic               bus_dat,
  input  logic               bus_en_n,
  output logic [RATIO_W-1:0] tx_ratio,
  output logic [RATIO_W-1:0] rx_ratio,
  output logic               tx_upd,
  output logic               rx_upd
);
  localparam int NLINES = 3;

  logic [NLINES-1:0] s_bus;
  logic              shift_ev, xfer_ev, en_idle;
  logic              clr;
  logic [WORD_W-1:0] sr_word, sr_next;

  assign clr = ~pd_n;

  serprog_sync #(.W(NLINES), .STAGES(SYNC_N), .RST_VAL(3'b100)) u_sync (
    .clk (clk),
    .rst (rst),
    .din ({bus_en_n, bus_clk, bus_dat}),
    .dout(s_bus)
  );

  serprog_edge u_edge (
    .clk     (clk),
    .rst     (rst),
    .s_clk   (s_bus[1]),
    .s_en    (s_bus[2]),
    .shift_ev(shift_ev),
    .xfer_ev (xfer_ev),
    .en_idle (en_idle)
  );

  serprog_shreg #(.WORD_W(WORD_W)) u_shreg (
    .clk      (clk),
    .rst      (rst),
    .clr      (clr),
    .shift_en (shift_ev & pd_n),
    .din      (s_bus[0]),
    .word     (sr_word),
    .next_word(sr_next)
  );

  serprog_latch #(.WORD_W(WORD_W), .RATIO_W(RATIO_W)) u_latch (
    .clk     (clk),
    .rst     (rst),
    .clr     (clr),
    .load    (xfer_ev & pd_n),
    .word    (sr_next),
    .tx_ratio(tx_ratio),
    .rx_ratio(rx_ratio),
    .tx_upd  (tx_upd),
    .rx_upd  (rx_upd)
  );

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk) disable iff (rst)
    (en_idle && pd_n) |=> $stable(sr_word)); // R2
  AST_UPD_NEEDS_XFER: assert property (@(posedge clk) disable iff (rst)
    (tx_upd || rx_upd) |-> $past(xfer_ev)); // R3
endmodule

// File: tb/serprog_rx_tb.sv
`timescale 1ns/1ps
module serprog_rx_tb;
  localparam int HOLD = 6;

  logic clk = 1'b0, rst = 1'b1, pd_n = 1'b1;
  logic bus_clk = 1'b0, bus_dat = 1'b0, bus_en_n = 1'b1;
  logic [12:0] tx_ratio, rx_ratio;
  logic tx_upd, rx_upd;

  int checks = 0, errors = 0;
  int tx_seen = 0, rx_seen = 0, tx_exp = 0, rx_exp = 0;
  logic [14:0] m_sr = '0;
  logic [12:0] m_tx = '0, m_rx = '0;
  bit done = 0;

  always #4 clk = ~clk;

  serprog_rx u_dut (
    .clk(clk), .rst(rst), .pd_n(pd_n), .bus_clk(bus_clk), .bus_dat(bus_dat),
    .bus_en_n(bus_en_n), .tx_ratio(tx_ratio), .rx_ratio(rx_ratio),
    .tx_upd(tx_upd), .rx_upd(rx_upd)
  );

  always @(negedge clk) begin
    if (!rst && tx_upd) tx_seen++;
    if (!rst && rx_upd) rx_seen++;
    if (!rst && tx_upd && rx_upd) begin
      checks++; errors++;
      $display("FAIL R7: both strobes high act=11 exp=not both");
    end
  end

  function automatic logic [14:0] f_shift(logic [14:0] sr, logic b);
    return {sr[13:0], b};
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic m_load();
    if (m_sr[0]) begin m_tx = m_sr[14:2]; tx_exp++; end
    else         begin m_rx = m_sr[14:2]; rx_exp++; end
  endtask

  task automatic send_bit(logic b);
    bus_dat = b; bus_clk = 1'b0; wait_n(HOLD);
    bus_clk = 1'b1; wait_n(HOLD);
    m_sr = f_shift(m_sr, b);
  endtask

  task automatic check_out(string req);
    chk(req, tx_ratio, m_tx);
    chk(req, rx_ratio, m_rx);
    chk({req, "/R7 tx strobes"}, tx_seen, tx_exp);
    chk({req, "/R7 rx strobes"}, rx_seen, rx_exp);
  endtask

  // mode 0: enable rises with clock high; 1: with clock low (extra shift);
  // 2: enable and last clock rise together
  task automatic burst(logic [31:0] bits, int n, int mode, logic xbit, string req);
    bus_en_n = 1'b0; wait_n(HOLD);
    for (int i = n - 1; i >= ((mode == 2) ? 1 : 0); i--) send_bit(bits[i]);
    chk("R3 mid-burst tx", tx_ratio, m_tx);
    chk("R3 mid-burst rx", rx_ratio, m_rx);
    if (mode == 1) begin
      bus_clk = 1'b0; bus_dat = xbit; wait_n(HOLD);
      bus_en_n = 1'b1; m_sr = f_shift(m_sr, xbit);
    end else if (mode == 2) begin
      bus_dat = bits[0]; bus_clk = 1'b0; wait_n(HOLD);
      bus_clk = 1'b1; bus_en_n = 1'b1; m_sr = f_shift(m_sr, bits[0]);
    end else begin
      bus_en_n = 1'b1;
    end
    m_load();
    wait_n(12);
    check_out(req);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    wait_n(5);
    rst = 1'b0;
    wait_n(2);
    // R9 reset state
    chk("R9 tx", tx_ratio, 0); chk("R9 rx", rx_ratio, 0);
    chk("R9 txupd", tx_upd, 0); chk("R9 rxupd", rx_upd, 0);

    // R1/R4: transmit word, ratio 0x1ABC, select 1
    burst({15'h1ABC, 2'b01}, 15, 0, 1'b0, "R1 R4 tx");
    // R4: receive word leaves tx untouched
    burst({15'h0123, 2'b00}, 15, 0, 1'b0, "R4 rx");
    // R10: reserved bit set, same ratio
    burst({15'h0123, 2'b10}, 15, 0, 1'b0, "R10 reserved");
    // R5: 20-bit burst, only last 15 matter
    burst(32'hFACE5, 20, 0, 1'b0, "R5 long burst");
    // R6: extra shift with clock low, data 1 turns into tx select
    burst(32'h0A5A, 14, 1, 1'b1, "R6 extra shift");
    // R6: enable and clock rise in the same cycle
    burst(32'h3C3D, 15, 2, 1'b0, "R6 simultaneous");
    // R2: clocks while enable high, then a short burst exposes register
    for (int i = 0; i < 5; i++) begin
      bus_dat = 1'b1; bus_clk = 1'b0; wait_n(HOLD);
      bus_clk = 1'b1; wait_n(HOLD);
    end
    burst(32'h2, 2, 0, 1'b0, "R2 ignored clocks");
    // R8: power-down clears latches and register
    pd_n = 1'b0; wait_n(4);
    chk("R8 tx", tx_ratio, 0); chk("R8 rx", rx_ratio, 0);
    chk("R8 txupd", tx_upd, 0);
    pd_n = 1'b1; m_sr = '0; m_tx = '0; m_rx = '0; wait_n(4);
    burst(32'h5, 3, 0, 1'b0, "R8 after power-down");

    // random bursts
    for (int k = 0; k < 40; k++) begin
      int n    = 1 + ($urandom % 22);
      int mode = $urandom % 3;
      burst($urandom, n, mode, 1'($urandom), "R1 R5 R6 random");
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule